// File: doc/BRIEF.md
# Register Slave with Read-Only Write Policy

This block is a small peripheral register slave on the APB bus. It exposes three words. The first is a fixed identification word that firmware reads to recognise the block. The second is a status word, wired straight from two hardware inputs: a busy flag and a 4-bit fill level. The third is an ordinary control word that software writes and reads back, and it drives a port into the surrounding logic.

The two read-only words have no storage and no write enable. A bus write aimed at either of them cannot move its value. A parameter chooses how the slave answers such a write. In lenient mode the transfer ends normally. In strict mode the transfer ends with PSLVERR high. The value is left untouched in both modes. PREADY is always high, so each transfer takes one setup cycle and one access cycle.

Top module: `apb_ro_regs`

## Requirements
- R1: Offset 0x10 is the identification word. It reads 32'hDEAD_0001 right after reset and after any amount of bus traffic.
- R2: Offset 0x14 is the status word. Bit 0 carries the busy input, bits 7:4 carry the 4-bit level input, and every other bit reads 0.
- R3: The status read value follows the hardware inputs combinationally. A change on the inputs, even one made during an access phase, appears without any write in between.
- R4: A write to 0x10 or 0x14 never changes what a later read of that offset returns, under either policy.
- R5: With STRICT_RO=0, a write to a read-only offset completes with PREADY=1 and PSLVERR=0.
- R6: With STRICT_RO=1, PSLVERR=1 in the access phase (PSEL=1, PENABLE=1, PWRITE=1) of a write whose address is 0x10 or 0x14.
- R7: A read of an unmapped offset returns 0, and read data is never undefined.
- R8: Reads never signal an error, under either policy.
- R9: The control word at offset 0x00 resets to 0. It loads PWDATA only in the access phase of a write to 0x00, and a setup phase alone leaves it unchanged.
- R10: PREADY is tied to 1, so every transfer takes exactly a setup cycle and an access cycle.
- R11: Writes to unmapped offsets are dropped and complete without error under both policies. The control word and later reads are unaffected.
- R12: PSLVERR is 0 whenever the bus is not in an access phase. PRESETn is an asynchronous, active-low reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, 0 when not reading |
| pready | output | 1 | Transfer-done, always 1 |
| pslverr | output | 1 | Error response for a strict-mode write to a read-only word |
| hw_busy | input | 1 | Live busy flag from the datapath |
| hw_level | input | 4 | Live fill level from the datapath |
| ctrl_out | output | DATA_W | Current control word |

## Verification
The bound checker watches every cycle for the following:
- a read of the identification word returns the constant;
- a read of the status word returns the current input bits at their positions;
- the error response follows the chosen policy on read-only writes and stays low for reads and outside access phases;
- PREADY stays high;
- the control word changes only in the access phase of a write to its own offset.

Some behaviours only the bench's scenarios can show, because each one spans several transfers:
- a read-only write followed by a read-back returns the old value;
- a status change made with no bus write shows up on the next read;
- the control word survives an unmapped write or a setup phase that is abandoned;
- an asynchronous reset clears the control word between clock edges.

The bench runs a lenient and a strict instance side by side on the same bus.

// File: rtl/apb_ro_regs.sv
module apb_ro_regs #(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 32,
  parameter bit                STRICT_RO = 1'b0,
  parameter logic [DATA_W-1:0] ID_WORD   = 32'hDEAD_0001
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              hw_busy,
  input  logic [3:0]        hw_level,
  output logic [DATA_W-1:0] ctrl_out
);

  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFS_ID   = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'('h14);

  logic              access_ph;
  logic              hit_ctrl, hit_id, hit_stat, hit_ro;
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] stat_word;

  assign access_ph = psel & penable;
  assign hit_ctrl  = (paddr == OFS_CTRL);
  assign hit_id    = (paddr == OFS_ID);
  assign hit_stat  = (paddr == OFS_STAT);
  assign hit_ro    = hit_id | hit_stat;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn)
      ctrl_q <= '0;
    else if (access_ph && pwrite && hit_ctrl)
      ctrl_q <= pwdata;
  end

  always_comb begin
    stat_word      = '0;
    stat_word[0]   = hw_busy;
    stat_word[7:4] = hw_level;
  end

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      if (hit_ctrl)      prdata = ctrl_q;
      else if (hit_id)   prdata = ID_WORD;
      else if (hit_stat) prdata = stat_word;
    end
  end

  assign pready   = 1'b1;
  assign pslverr  = STRICT_RO & access_ph & pwrite & hit_ro;
  assign ctrl_out = ctrl_q;

endmodule

// File: rtl/apb_ro_regs_chk.sv
module apb_ro_regs_chk #(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 32,
  parameter bit                STRICT_RO = 1'b0,
  parameter logic [DATA_W-1:0] ID_WORD   = 32'hDEAD_0001
) (
  input logic              pclk,
  input logic              presetn,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] pwdata,
  input logic [DATA_W-1:0] prdata,
  input logic              pready,
  input logic              pslverr,
  input logic              hw_busy,
  input logic [3:0]        hw_level,
  input logic [DATA_W-1:0] ctrl_out
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'('h14);

  logic [DATA_W-1:0] exp_stat;
  always_comb begin
    exp_stat      = '0;
    exp_stat[0]   = hw_busy;
    exp_stat[7:4] = hw_level;
  end

  a_r1_id_constant: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && !pwrite && paddr == A_ID) |-> (prdata == ID_WORD));

  a_r2_status_live: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && !pwrite && paddr == A_STAT) |-> (prdata == exp_stat));

  a_r5_lenient_ok: assert property (@(posedge pclk) disable iff (!presetn)
    (!STRICT_RO && psel && penable && pwrite && (paddr == A_ID || paddr == A_STAT))
      |-> (pready && !pslverr));

  a_r6_strict_err: assert property (@(posedge pclk) disable iff (!presetn)
    (STRICT_RO && psel && penable && pwrite && (paddr == A_ID || paddr == A_STAT))
      |-> pslverr);

  a_r8_read_no_err: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !pwrite) |-> !pslverr);

  a_r9_ctrl_guarded: assert property (@(posedge pclk) disable iff (!presetn)
    !(psel && penable && pwrite && paddr == A_CTRL) |=> $stable(ctrl_out));

  a_r10_ready_high: assert property (@(posedge pclk) disable iff (!presetn)
    pready);

  a_r12_idle_no_err: assert property (@(posedge pclk) disable iff (!presetn)
    !(psel && penable) |-> !pslverr);

endmodule

bind apb_ro_regs apb_ro_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STRICT_RO(STRICT_RO), .ID_WORD(ID_WORD)
) u_chk (
  .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
  .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
  .pready(pready), .pslverr(pslverr), .hw_busy(hw_busy),
  .hw_level(hw_level), .ctrl_out(ctrl_out)
);

// File: tb/tb_apb_ro_regs.sv
`timescale 1ns/1ps
module tb_apb_ro_regs;
  logic        clk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic        hw_busy = 1'b0;
  logic [3:0]  hw_level = '0;
  logic [31:0] rd_l, rd_s, ctl_l, ctl_s;
  logic        rdy_l, rdy_s, err_l, err_s;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  apb_ro_regs #(.STRICT_RO(1'b0)) dut (
    .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(rd_l),
    .pready(rdy_l), .pslverr(err_l), .hw_busy(hw_busy),
    .hw_level(hw_level), .ctrl_out(ctl_l));

  apb_ro_regs #(.STRICT_RO(1'b1)) dut_strict (
    .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(rd_s),
    .pready(rdy_s), .pslverr(err_s), .hw_busy(hw_busy),
    .hw_level(hw_level), .ctrl_out(ctl_s));

  // fields: wr[78] addr[77:70] wdata[69:38] busy[37] lvl[36:33] exp[32:1] strict_err[0]
  localparam int NV = 13;
  localparam logic [78:0] VEC [NV] = '{
    {1'b0, 8'h10, 32'h0,         1'b0, 4'h0, 32'hDEAD_0001, 1'b0},
    {1'b0, 8'h14, 32'h0,         1'b1, 4'h5, 32'h0000_0051, 1'b0},
    {1'b0, 8'h14, 32'h0,         1'b0, 4'hF, 32'h0000_00F0, 1'b0},
    {1'b1, 8'h14, 32'hFFFF_FFFF, 1'b0, 4'hF, 32'h0,         1'b1},
    {1'b0, 8'h14, 32'h0,         1'b0, 4'hF, 32'h0000_00F0, 1'b0},
    {1'b1, 8'h10, 32'h0,         1'b0, 4'hF, 32'h0,         1'b1},
    {1'b0, 8'h10, 32'h0,         1'b0, 4'hF, 32'hDEAD_0001, 1'b0},
    {1'b1, 8'h00, 32'hA5A5_1234, 1'b0, 4'hF, 32'h0,         1'b0},
    {1'b0, 8'h00, 32'h0,         1'b0, 4'hF, 32'hA5A5_1234, 1'b0},
    {1'b1, 8'h20, 32'h0000_FFFF, 1'b0, 4'hF, 32'h0,         1'b0},
    {1'b0, 8'h20, 32'h0,         1'b0, 4'hF, 32'h0,         1'b0},
    {1'b0, 8'h00, 32'h0,         1'b0, 4'hF, 32'hA5A5_1234, 1'b0},
    {1'b0, 8'h14, 32'h0,         1'b1, 4'h0, 32'h0000_0001, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [7:0] a, input logic [31:0] d,
                      output logic [31:0] ol, output logic [31:0] os,
                      output logic el, output logic es, output logic rl, output logic rs);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    #1;
    chk("R12 setup err strict", {31'b0, err_s}, 32'd0);
    @(negedge clk);
    penable = 1'b1;
    #1;
    ol = rd_l; os = rd_s; el = err_l; es = err_s; rl = rdy_l; rs = rdy_s;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    #1;
    chk("R12 idle err strict", {31'b0, err_s}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] ol, os;
    logic el, es, rl, rs;
    #12 presetn = 1'b1;
    #1;
    chk("R9 ctrl reset lenient", ctl_l, 32'd0);
    chk("R9 ctrl reset strict", ctl_s, 32'd0);
    chk("R12 err at reset", {31'b0, err_s}, 32'd0);
    xfer(1'b0, 8'h00, 32'h0, ol, os, el, es, rl, rs);
    chk("R9 ctrl reads 0 after reset", ol, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [78:0] v;
      v = VEC[i];
      hw_busy = v[37]; hw_level = v[36:33];
      xfer(v[78], v[77:70], v[69:38], ol, os, el, es, rl, rs);
      chk("R10 pready lenient", {31'b0, rl}, 32'd1);
      chk("R10 pready strict", {31'b0, rs}, 32'd1);
      if (v[78]) begin
        chk("R5 R11 lenient write err", {31'b0, el}, 32'd0);
        chk("R6 R11 strict write err", {31'b0, es}, {31'b0, v[0]});
      end else begin
        chk("R1 R2 R4 R7 R9 read lenient", ol, v[32:1]);
        chk("R1 R2 R4 R7 R9 read strict", os, v[32:1]);
        chk("R8 read err lenient", {31'b0, el}, 32'd0);
        chk("R8 read err strict", {31'b0, es}, 32'd0);
      end
    end
    chk("R11 ctrl after unmapped write", ctl_s, 32'hA5A5_1234);

    // R3: inputs change mid-access, read data follows with no write
    @(negedge clk);
    hw_busy = 1'b0; hw_level = 4'h3;
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = 8'h14;
    @(negedge clk);
    penable = 1'b1;
    #1;
    chk("R3 live read before change", rd_l, 32'h0000_0030);
    hw_level = 4'hA; hw_busy = 1'b1;
    #1;
    chk("R3 live read after change", rd_l, 32'h0000_00A1);
    chk("R3 live read strict", rd_s, 32'h0000_00A1);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;

    // R9: setup phase only, abandoned, must not load ctrl
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 8'h00; pwdata = 32'h1111_1111;
    @(negedge clk);
    psel = 1'b0; pwrite = 1'b0;
    #1;
    chk("R9 setup-only no load", ctl_l, 32'hA5A5_1234);

    // R12: asynchronous reset clears ctrl between edges
    @(posedge clk);
    #1 presetn = 1'b0;
    #0.5;
    chk("R12 async reset ctrl", ctl_l, 32'd0);
    chk("R12 async reset ctrl strict", ctl_s, 32'd0);
    #5 presetn = 1'b1;
    xfer(1'b0, 8'h10, 32'h0, ol, os, el, es, rl, rs);
    chk("R1 id after reset", os, 32'hDEAD_0001);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule